// File: doc/BRIEF.md
# Partition-Label System Register Access Controller

This block owns a 64-bit configuration register that carries partition labels for memory requests: an identifier and a monitoring group for data accesses, another pair for instruction fetches, and three single-bit status fields. Each register access arrives as a one-cycle request. The request carries the privilege level (0 to 3), the direction, and whether the primary or the alias encoding was used. The block decides the outcome. The access may reach this register, be passed to the level-2 (hypervisor) register, be redirected to a fixed memory offset, trap to level 2 or level 3, or be undefined.

The decision follows a fixed order of checks. The inputs to those checks are which levels are implemented, whether level 2 is enabled, the host-mode flag, three nested-virtualization control bits, two trap enables, the security state, and a secure-debug-disable condition. One cycle after the request, the block returns the outcome, the trap syndrome class, the redirect offset and the read data, all registered. A write reaches the storage only when the outcome is this register, and only through the write mask. The enable bit, the forced-non-secure bit and the alternate-space bit are read-only views of control state held elsewhere.

Top module: `pl_sysreg_ctrl`

## Requirements
- R1: Outcome codes on `rsp_outcome` are 0 = this register, 1 = level-2 register, 2 = memory redirect, 3 = trap to level 2, 4 = trap to level 3, 5 = undefined. Every request at level 0 yields 5.
- R2: At level 1 with the primary encoding, checks run in this order, and the first that matches decides the outcome:
  - level 3 implemented and its trap-lower bit set gives 4, or 5 when secure debug is disabled;
  - level 2 enabled and its trap bit set gives 3;
  - nested-virtualization bits equal to 3'b111 give 2;
  - in every other case the outcome is 0.
- R3: Outcomes 3 and 4 report syndrome class 0x18, and outcome 2 reports offset 0x900. Every other outcome reports zero in both fields.
- R4: At level 2 with the primary encoding, the level-3 trap-lower check of R2 comes first. After it, host mode gives 1, and in every other case the outcome is 0.
- R5: At level 3 the primary encoding always yields 0.
- R6: At level 1 with the alias encoding, the checks run in this order:
  - nested-virtualization bits equal to 3'b101 give 2;
  - otherwise, bit 0 of those bits set gives a trap: 4 if level 3 is implemented with trap-lower set, else 3;
  - in every other case the outcome is 5.
- R7: At levels 2 and 3 the alias encoding yields 5 unless host mode is set. In host mode, level 2 first applies the level-3 trap-lower check of R2 and otherwise gives 0, and level 3 gives 0.
- R8: Register layout:
  - bit 63: enable;
  - bit 60: forced non-secure;
  - bit 54: alternate space forced;
  - bits 47:40: data group;
  - bits 39:32: instruction group;
  - bits 31:16: data identifier;
  - bits 15:0: instruction identifier.
  A write with outcome 0 updates only bits 47:0. All other bits ignore writes, and the reserved bits read 0.
- R9: Bit 63 reads the level-3 enable when level 3 is implemented, otherwise the level-2 enable when level 2 is implemented, otherwise 0.
- R10: Bit 60 reads 0 in the non-secure state. In the secure state with level 3 implemented, it reads the level-3 force-non-secure control.
- R11: Reset clears the stored fields and `rsp_valid`. Each request produces exactly one `rsp_valid` pulse on the next cycle.
- R12: `rsp_rdata` holds the register value only for a read whose outcome is 0, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_alias | input | 1 | 1 = alias encoding, 0 = primary |
| req_level | input | 2 | Current privilege level |
| req_wdata | input | 64 | Write data |
| has_l3 | input | 1 | Level 3 implemented |
| has_l2 | input | 1 | Level 2 implemented |
| l2_active | input | 1 | Level 2 enabled in current security state |
| host_mode | input | 1 | Hypervisor host-mode flag |
| nv_bits | input | 3 | Nested-virtualization controls |
| l3_trap_lower | input | 1 | Level-3 trap of lower-level accesses |
| l2_trap_reg | input | 1 | Level-2 trap of this register |
| sec_debug_off | input | 1 | Secure debug disabled: level-3 traps become undefined |
| secure_state | input | 1 | 1 = secure state |
| l3_label_en | input | 1 | Level-3 enable control |
| l2_label_en | input | 1 | Level-2 enable control |
| l3_force_ns | input | 1 | Level-3 force-non-secure control |
| alt_space_on | input | 1 | Alternate space forced by a higher level |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 3 | Outcome code |
| rsp_syndrome | output | 6 | Trap syndrome class |
| rsp_offset | output | 12 | Redirect memory offset |
| rsp_rdata | output | 64 | Read data |

## Verification
The bench sweeps every combination of level, encoding, host mode, nested-virtualization bits, both trap enables, level-3 presence, level-2 enable and secure-debug-disable against a priority function built from the requirements. A design that put the level-2 trap ahead of the level-3 trap, or the redirect ahead of either trap, would report the wrong trap level or a redirect. A design that missed the 3'b101 alias case would trap where it should redirect. Directed tasks write all-ones and check that the reserved and mirrored bits stay as the requirements state. A design with a loose write mask would read back a set reserved bit, and a wrong mirror source would show the wrong enable when only level 2 exists. A further check writes at level 1 while a trap applies; a design that let that write reach storage would change the value seen by the next level-3 read.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic [2:0] {
    OC_SELF  = 3'd0,
    OC_HYP   = 3'd1,
    OC_MEM   = 3'd2,
    OC_TRAP2 = 3'd3,
    OC_TRAP3 = 3'd4,
    OC_UNDEF = 3'd5
  } outcome_e;

  localparam int REG_W      = 64;
  localparam int BIT_EN     = 63;
  localparam int BIT_FNS    = 60;
  localparam int BIT_ALT    = 54;
  localparam int WRITE_TOP  = 47;
endpackage

// File: rtl/pl_access_decode.sv
module pl_access_decode
  import pl_pkg::*;
(
  input  logic       is_alias,
  input  logic [1:0] level,
  input  logic       has_l3,
  input  logic       l2_active,
  input  logic       host_mode,
  input  logic [2:0] nv_bits,
  input  logic       l3_trap_lower,
  input  logic       l2_trap_reg,
  input  logic       sec_debug_off,
  output outcome_e   outcome
);
  logic     l3_trap_hit;
  outcome_e l3_trap_res;

  always_comb begin
    l3_trap_hit = has_l3 && l3_trap_lower;
    l3_trap_res = sec_debug_off ? OC_UNDEF : OC_TRAP3;
  end

  always_comb begin
    outcome = OC_UNDEF;
    unique case (level)
      2'd0: outcome = OC_UNDEF;
      2'd1: begin
        if (!is_alias) begin
          if (l3_trap_hit)                  outcome = l3_trap_res;
          else if (l2_active && l2_trap_reg) outcome = OC_TRAP2;
          else if (nv_bits == 3'b111)       outcome = OC_MEM;
          else                              outcome = OC_SELF;
        end else begin
          if (nv_bits == 3'b101)            outcome = OC_MEM;
          else if (nv_bits[0])              outcome = l3_trap_hit ? OC_TRAP3 : OC_TRAP2;
          else                              outcome = OC_UNDEF;
        end
      end
      2'd2: begin
        if (!is_alias) begin
          if (l3_trap_hit)    outcome = l3_trap_res;
          else if (host_mode) outcome = OC_HYP;
          else                outcome = OC_SELF;
        end else if (host_mode) begin
          outcome = l3_trap_hit ? l3_trap_res : OC_SELF;
        end else begin
          outcome = OC_UNDEF;
        end
      end
      default: begin
        if (!is_alias)      outcome = OC_SELF;
        else if (host_mode) outcome = OC_SELF;
        else                outcome = OC_UNDEF;
      end
    endcase
  end
endmodule

// File: rtl/pl_label_store.sv
module pl_label_store
  import pl_pkg::*;
#(
  parameter int DATA_W     = REG_W,
  parameter bit HAS_ALT_SP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mirror_en,
  input  logic              mirror_fns,
  input  logic              mirror_alt,
  output logic [DATA_W-1:0] rd_value
);
  localparam int HELD_W = WRITE_TOP + 1;

  logic [HELD_W-1:0] held;
  logic              alt_bit;

  always_ff @(posedge clk) begin
    if (rst)        held <= '0;
    else if (wr_en) held <= wr_data[HELD_W-1:0];
  end

  generate
    if (HAS_ALT_SP) begin : g_alt
      assign alt_bit = mirror_alt;
    end else begin : g_no_alt
      assign alt_bit = 1'b0;
    end
  endgenerate

  always_comb begin
    rd_value           = '0;
    rd_value[HELD_W-1:0] = held;
    rd_value[BIT_EN]   = mirror_en;
    rd_value[BIT_FNS]  = mirror_fns;
    rd_value[BIT_ALT]  = alt_bit;
  end

  AST_HELD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(held)); // R8
endmodule

// File: rtl/pl_sysreg_ctrl.sv
module pl_sysreg_ctrl
  import pl_pkg::*;
#(
  parameter int          DATA_W     = REG_W,
  parameter int          SYN_W      = 6,
  parameter int          OFS_W      = 12,
  parameter logic [5:0]  TRAP_CLASS = 6'h18,
  parameter logic [11:0] REDIR_OFS  = 12'h900,
  parameter bit          HAS_ALT_SP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_alias,
  input  logic [1:0]        req_level,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              has_l3,
  input  logic              has_l2,
  input  logic              l2_active,
  input  logic              host_mode,
  input  logic [2:0]        nv_bits,
  input  logic              l3_trap_lower,
  input  logic              l2_trap_reg,
  input  logic              sec_debug_off,
  input  logic              secure_state,
  input  logic              l3_label_en,
  input  logic              l2_label_en,
  input  logic              l3_force_ns,
  input  logic              alt_space_on,
  output logic              rsp_valid,
  output logic [2:0]        rsp_outcome,
  output logic [SYN_W-1:0]  rsp_syndrome,
  output logic [OFS_W-1:0]  rsp_offset,
  output logic [DATA_W-1:0] rsp_rdata
);
  outcome_e          dec_out;
  logic              grant_self;
  logic              mirror_en;
  logic              mirror_fns;
  logic [DATA_W-1:0] reg_value;

  pl_access_decode u_decode (
    .is_alias      (req_alias),
    .level         (req_level),
    .has_l3        (has_l3),
    .l2_active     (l2_active),
    .host_mode     (host_mode),
    .nv_bits       (nv_bits),
    .l3_trap_lower (l3_trap_lower),
    .l2_trap_reg   (l2_trap_reg),
    .sec_debug_off (sec_debug_off),
    .outcome       (dec_out)
  );

  always_comb begin
    grant_self = req_valid && (dec_out == OC_SELF);
    if (has_l3)      mirror_en = l3_label_en;
    else if (has_l2) mirror_en = l2_label_en;
    else             mirror_en = 1'b0;
    mirror_fns = secure_state && has_l3 && l3_force_ns;
  end

  pl_label_store #(.DATA_W(DATA_W), .HAS_ALT_SP(HAS_ALT_SP)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (grant_self && req_write),
    .wr_data    (req_wdata),
    .mirror_en  (mirror_en),
    .mirror_fns (mirror_fns),
    .mirror_alt (alt_space_on),
    .rd_value   (reg_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_outcome  <= 3'd0;
      rsp_syndrome <= '0;
      rsp_offset   <= '0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_outcome  <= req_valid ? dec_out : 3'd0;
      rsp_syndrome <= (req_valid && (dec_out == OC_TRAP2 || dec_out == OC_TRAP3))
                      ? SYN_W'(TRAP_CLASS) : '0;
      rsp_offset   <= (req_valid && dec_out == OC_MEM) ? OFS_W'(REDIR_OFS) : '0;
      rsp_rdata    <= (grant_self && !req_write) ? reg_value : '0;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R11
  AST_LEVEL0_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_level == 2'd0) |=> rsp_outcome == 3'd5); // R1
  AST_TOP_PRIMARY_SELF: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_level == 2'd3 && !req_alias) |=> rsp_outcome == 3'd0); // R5
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_outcome == 3'd3 || rsp_outcome == 3'd4))
      |-> rsp_syndrome == SYN_W'(TRAP_CLASS)); // R3
  AST_RDATA_ONLY_SELF: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome != 3'd0) |-> rsp_rdata == '0); // R12
endmodule

// File: tb/pl_sysreg_ctrl_tb.sv
module pl_sysreg_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0, req_alias = 0;
  logic [1:0]  req_level = 0;
  logic [63:0] req_wdata = 0;
  logic        has_l3 = 0, has_l2 = 1, l2_active = 0, host_mode = 0;
  logic [2:0]  nv_bits = 0;
  logic        l3_trap_lower = 0, l2_trap_reg = 0, sec_debug_off = 0;
  logic        secure_state = 0, l3_label_en = 0, l2_label_en = 0;
  logic        l3_force_ns = 0, alt_space_on = 0;
  logic        rsp_valid;
  logic [2:0]  rsp_outcome;
  logic [5:0]  rsp_syndrome;
  logic [11:0] rsp_offset;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pl_sysreg_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_alias(req_alias), .req_level(req_level), .req_wdata(req_wdata),
    .has_l3(has_l3), .has_l2(has_l2), .l2_active(l2_active),
    .host_mode(host_mode), .nv_bits(nv_bits), .l3_trap_lower(l3_trap_lower),
    .l2_trap_reg(l2_trap_reg), .sec_debug_off(sec_debug_off),
    .secure_state(secure_state), .l3_label_en(l3_label_en),
    .l2_label_en(l2_label_en), .l3_force_ns(l3_force_ns),
    .alt_space_on(alt_space_on), .rsp_valid(rsp_valid),
    .rsp_outcome(rsp_outcome), .rsp_syndrome(rsp_syndrome),
    .rsp_offset(rsp_offset), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit al, input logic [1:0] lvl,
                        input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_alias = al; req_level = lvl; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  function automatic logic [2:0] ref_out(input bit al, input int lvl, input bit hm,
      input logic [2:0] nv, input bit tl, input bit t2, input bit h3, input bit l2e,
      input bit sdd);
    bit t3 = h3 && tl;
    logic [2:0] t3r = sdd ? 3'd5 : 3'd4;
    if (lvl == 0) return 3'd5;
    if (lvl == 3) return (!al || hm) ? 3'd0 : 3'd5;
    if (lvl == 2) begin
      if (al && !hm) return 3'd5;
      if (t3) return t3r;
      if (!al && hm) return 3'd1;
      return 3'd0;
    end
    if (!al) begin
      if (t3) return t3r;
      if (l2e && t2) return 3'd3;
      if (nv == 3'b111) return 3'd2;
      return 3'd0;
    end
    if (nv == 3'b101) return 3'd2;
    if (nv[0]) return t3 ? 3'd4 : 3'd3;
    return 3'd5;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(rsp_valid == 0, "R11 reset valid", 64'(rsp_valid), 0);
    chk(rsp_rdata == 0, "R11 reset rdata", rsp_rdata, 0);
    rst = 0;
    has_l3 = 0; has_l2 = 0;
    access(0, 0, 2'd3, 0);
    chk(rsp_valid == 1, "R11 response pulse", 64'(rsp_valid), 1);
    chk(rsp_rdata == 0, "R11 fields zero after reset", rsp_rdata, 0);
    @(negedge clk);
    chk(rsp_valid == 0, "R11 single pulse", 64'(rsp_valid), 0);
  endtask

  task automatic t_sweep;
    int bad = 0;
    has_l2 = 1;
    for (int lv = 0; lv < 4; lv++)
      for (int al = 0; al < 2; al++)
        for (int hm = 0; hm < 2; hm++)
          for (int nv = 0; nv < 8; nv++)
            for (int k = 0; k < 32; k++) begin
              logic [2:0] e;
              host_mode = hm[0]; nv_bits = nv[2:0];
              l3_trap_lower = k[0]; l2_trap_reg = k[1]; has_l3 = k[2];
              l2_active = k[3]; sec_debug_off = k[4];
              e = ref_out(al[0], lv, hm[0], nv[2:0], k[0], k[1], k[2], k[3], k[4]);
              access(0, al[0], lv[1:0], 0);
              if (rsp_outcome != e) begin
                bad++;
                chk(0, "R1 R2 R4 R5 R6 R7 outcome", 64'(rsp_outcome), 64'(e));
              end else if ((e == 3 || e == 4) ? (rsp_syndrome != 6'h18)
                                              : (rsp_syndrome != 0)) begin
                chk(0, "R3 syndrome", 64'(rsp_syndrome), (e == 3 || e == 4) ? 64'h18 : 0);
              end else if ((e == 2) ? (rsp_offset != 12'h900) : (rsp_offset != 0)) begin
                chk(0, "R3 offset", 64'(rsp_offset), (e == 2) ? 64'h900 : 0);
              end else if (e != 0 && rsp_rdata != 0) begin
                chk(0, "R12 rdata zero", rsp_rdata, 0);
              end
            end
    chk(bad == 0, "R2 R6 sweep mismatches", 64'(bad), 0);
    host_mode = 0; nv_bits = 0; l3_trap_lower = 0; l2_trap_reg = 0;
    has_l3 = 0; l2_active = 0; sec_debug_off = 0;
  endtask

  task automatic t_write_mask;
    has_l3 = 0; has_l2 = 0; secure_state = 0; alt_space_on = 0;
    access(1, 0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(rsp_outcome == 0 && rsp_rdata == 0, "R12 write returns no data", rsp_rdata, 0);
    access(0, 0, 2'd1, 0);
    chk(rsp_rdata == 64'h0000_FFFF_FFFF_FFFF, "R8 write mask", rsp_rdata,
        64'h0000_FFFF_FFFF_FFFF);
    access(1, 0, 2'd3, 64'h1234_5678_9ABC_DEF0);
    access(0, 0, 2'd1, 0);
    chk(rsp_rdata == 64'h0000_5678_9ABC_DEF0, "R8 field layout", rsp_rdata,
        64'h0000_5678_9ABC_DEF0);
  endtask

  task automatic t_blocked_write;
    has_l3 = 1; l3_trap_lower = 1;
    access(1, 0, 2'd1, 64'h0000_1111_2222_3333);
    chk(rsp_outcome == 4, "R2 trapped write", 64'(rsp_outcome), 4);
    l3_trap_lower = 0;
    access(0, 0, 2'd3, 0);
    chk(rsp_rdata[47:0] == 48'h5678_9ABC_DEF0, "R8 trapped write ignored",
        64'(rsp_rdata[47:0]), 64'h5678_9ABC_DEF0);
    has_l3 = 0;
  endtask

  task automatic t_mirror;
    has_l3 = 1; l3_label_en = 1; l2_label_en = 0;
    access(0, 0, 2'd3, 0);
    chk(rsp_rdata[63] == 1, "R9 enable from level 3", 64'(rsp_rdata[63]), 1);
    has_l3 = 0; has_l2 = 1; l3_label_en = 0; l2_label_en = 1;
    access(0, 0, 2'd3, 0);
    chk(rsp_rdata[63] == 1, "R9 enable from level 2", 64'(rsp_rdata[63]), 1);
    has_l2 = 0;
    access(1, 0, 2'd3, 64'h8000_0000_0000_0000);
    access(0, 0, 2'd3, 0);
    chk(rsp_rdata[63] == 0, "R9 no higher level", 64'(rsp_rdata[63]), 0);
    l2_label_en = 0;
  endtask

  task automatic t_fns_alt;
    has_l3 = 1; l3_force_ns = 1; secure_state = 0;
    access(1, 0, 2'd3, 64'h1000_0000_0000_0000);
    access(0, 0, 2'd3, 0);
    chk(rsp_rdata[60] == 0, "R10 non-secure reads zero", 64'(rsp_rdata[60]), 0);
    secure_state = 1;
    access(0, 0, 2'd3, 0);
    chk(rsp_rdata[60] == 1, "R10 secure mirrors force", 64'(rsp_rdata[60]), 1);
    alt_space_on = 1;
    access(0, 0, 2'd3, 0);
    chk(rsp_rdata[54] == 1, "R8 alternate space bit", 64'(rsp_rdata[54]), 1);
    chk(rsp_rdata[62:61] == 0 && rsp_rdata[59:55] == 0 && rsp_rdata[53:48] == 0,
        "R8 reserved zero", rsp_rdata, 0);
    has_l3 = 0; l3_force_ns = 0; secure_state = 0; alt_space_on = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_write_mask();
    t_blocked_write();
    t_mirror();
    t_fns_alt();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule